// File: doc/BRIEF.md
# Node Slot Scoreboard

This block keeps a bank of node slots, each carrying one graph node through its processing lifecycle on an accelerator. A host fills a free slot with a node identifier, a precision code and the start address of the node's neighbour list. It then strobes that slot's make-valid bit. From there the slot advances without further host action. It requests a neighbour-list fetch, then a fetch of the neighbour data, then an aggregation pass, and finally a transformation pass shared with other slots. After that it falls back to the free state and raises a per-slot interrupt.

Each engine sits behind a valid/ready request port that the slots share. One slot wins each port per cycle under round-robin arbitration. Completions come back as a valid pulse tagged with a slot index. Transformation work is batched. A single request names every slot whose aggregation has finished. It is raised once the number of such slots reaches a host-programmed wait count. The host reads a mask of free slots to choose where to place the next node. It reads a mask of slots whose incoming data is fully fetched for debug.

Top module: `node_slot_scoreboard`

## Requirements
- R1: After reset every slot is free: `empty_mask` is all ones, `irq_mask`, `fetched_mask`, `irq` and all request valids are zero.
- R2: A `make_valid` bit moves a free slot out of the free state, so its `empty_mask` bit is 0 from the next cycle on. A `make_valid` bit for a slot that is not free is ignored.
- R3: A programming write (`prog_we` with `prog_slot`) is stored only while the addressed slot is free. The stored address appears on `nbl_req_addr`, and the stored node ID and precision appear on `agg_req_node`/`agg_req_prec` when that slot is the one presented.
- R4: A slot leaving the free state requests a neighbour-list fetch. It stays requesting, with `nbl_req_valid` held high, while `nbl_req_ready` is low. It moves on only in the cycle its request is accepted.
- R5: A neighbour-list done for a slot makes that slot request a neighbour-data fetch. A neighbour-data done, whether OK or partial, makes it request aggregation.
- R6: On each request port the slot granted is the first requesting slot at or after a rotating pointer, counting upward and wrapping. After an accepted request the pointer moves to the slot after the granted one. Otherwise it holds.
- R7: `xf_req_valid` is high exactly when `xform_wait` is nonzero and the count of slots with finished aggregation is at least `xform_wait`. `xf_req_mask` names those slots, and acceptance moves all of them into transformation together.
- R8: A transformation done for a slot returns it to the free state, sets its `irq_mask` bit, and lets it be programmed and validated again at once.
- R9: `irq_mask` bits are cleared by writing one to `irq_clear`. A set and a clear of the same bit in one cycle leave it set. `irq` is high while any bit is set.
- R10: A slot's `fetched_mask` bit is set by an OK neighbour-data done (`nbr_done_partial`=0) or by a later all-fetched update on `late_done_*`. It is cleared when the slot is validated again.
- R11: A done response naming a slot that is not waiting for that response has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| prog_we | input | 1 | Programming write strobe |
| prog_slot | input | SID_W | Slot written by the programming strobe |
| prog_node | input | NODE_W | Node identifier to store |
| prog_prec | input | PREC_W | Precision code to store |
| prog_addr | input | ADDR_W | Neighbour-list start address to store |
| make_valid | input | SLOTS | One-cycle make-valid strobe, one bit per slot |
| irq_clear | input | SLOTS | Write-one-to-clear for interrupt bits |
| xform_wait | input | CNT_W | Aggregated-slot count that triggers a transformation request |
| nbl_req_valid | output | 1 | Neighbour-list fetch request valid |
| nbl_req_ready | input | 1 | Prefetcher accepts neighbour-list request |
| nbl_req_slot | output | SID_W | Slot of the neighbour-list request |
| nbl_req_addr | output | ADDR_W | Start address of the neighbour list |
| nbl_done_valid | input | 1 | Neighbour-list fetch done |
| nbl_done_slot | input | SID_W | Slot of the neighbour-list done |
| nbr_req_valid | output | 1 | Neighbour-data fetch request valid |
| nbr_req_ready | input | 1 | Prefetcher accepts neighbour-data request |
| nbr_req_slot | output | SID_W | Slot of the neighbour-data request |
| nbr_done_valid | input | 1 | Neighbour-data fetch done |
| nbr_done_slot | input | SID_W | Slot of the neighbour-data done |
| nbr_done_partial | input | 1 | 1 = partial completion, 0 = all data fetched |
| late_done_valid | input | 1 | Later all-data-fetched update |
| late_done_slot | input | SID_W | Slot of the later update |
| agg_req_valid | output | 1 | Aggregation request valid |
| agg_req_ready | input | 1 | Aggregation engine accepts request |
| agg_req_slot | output | SID_W | Slot of the aggregation request |
| agg_req_node | output | NODE_W | Node identifier of that slot |
| agg_req_prec | output | PREC_W | Precision code of that slot |
| agg_done_valid | input | 1 | Aggregation done |
| agg_done_slot | input | SID_W | Slot of the aggregation done |
| xf_req_valid | output | 1 | Batched transformation request valid |
| xf_req_ready | input | 1 | Transformation engine accepts the batch |
| xf_req_mask | output | SLOTS | Slots included in the batch |
| xf_done_valid | input | 1 | Transformation done |
| xf_done_slot | input | SID_W | Slot of the transformation done |
| empty_mask | output | SLOTS | 1 for each free slot |
| fetched_mask | output | SLOTS | 1 for each slot with all incoming data fetched |
| irq_mask | output | SLOTS | Per-slot completion interrupt |
| irq | output | 1 | OR of all interrupt bits |

## Verification
The bench builds the block with four slots and a two-bit slot index, and sets the transformation wait count to three. At that size every slot can be driven through every state. The pointer wrap of each round-robin port happens within a handful of grants, so the grant order can be predicted by hand for both a wrapped and an unwrapped pointer. Four slots also let the wait count be crossed exactly and then overshot while the batch is held back. The ignored cases can be seen at the masks and request ports: a re-strobe of a busy slot, a write to a busy slot, and a stray done for an idle slot.

// File: rtl/node_slot_scoreboard.sv
module node_slot_scoreboard #(
  parameter int SLOTS  = 64,
  parameter int NODE_W = 20,
  parameter int PREC_W = 2,
  parameter int ADDR_W = 32,
  localparam int SID_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              prog_we,
  input  logic [SID_W-1:0]  prog_slot,
  input  logic [NODE_W-1:0] prog_node,
  input  logic [PREC_W-1:0] prog_prec,
  input  logic [ADDR_W-1:0] prog_addr,
  input  logic [SLOTS-1:0]  make_valid,
  input  logic [SLOTS-1:0]  irq_clear,
  input  logic [CNT_W-1:0]  xform_wait,
  output logic              nbl_req_valid,
  input  logic              nbl_req_ready,
  output logic [SID_W-1:0]  nbl_req_slot,
  output logic [ADDR_W-1:0] nbl_req_addr,
  input  logic              nbl_done_valid,
  input  logic [SID_W-1:0]  nbl_done_slot,
  output logic              nbr_req_valid,
  input  logic              nbr_req_ready,
  output logic [SID_W-1:0]  nbr_req_slot,
  input  logic              nbr_done_valid,
  input  logic [SID_W-1:0]  nbr_done_slot,
  input  logic              nbr_done_partial,
  input  logic              late_done_valid,
  input  logic [SID_W-1:0]  late_done_slot,
  output logic              agg_req_valid,
  input  logic              agg_req_ready,
  output logic [SID_W-1:0]  agg_req_slot,
  output logic [NODE_W-1:0] agg_req_node,
  output logic [PREC_W-1:0] agg_req_prec,
  input  logic              agg_done_valid,
  input  logic [SID_W-1:0]  agg_done_slot,
  output logic              xf_req_valid,
  input  logic              xf_req_ready,
  output logic [SLOTS-1:0]  xf_req_mask,
  input  logic              xf_done_valid,
  input  logic [SID_W-1:0]  xf_done_slot,
  output logic [SLOTS-1:0]  empty_mask,
  output logic [SLOTS-1:0]  fetched_mask,
  output logic [SLOTS-1:0]  irq_mask,
  output logic              irq
);

  typedef enum logic [2:0] {S_EMPTY, S_PROG, S_NBL, S_NBR, S_AGG, S_XF} slot_st_e;

  slot_st_e          st_q   [SLOTS];
  logic [NODE_W-1:0] node_q [SLOTS];
  logic [PREC_W-1:0] prec_q [SLOTS];
  logic [ADDR_W-1:0] addr_q [SLOTS];
  logic [SLOTS-1:0]  pend_q, agd_q, fetched_q, irq_q;
  logic [SLOTS-1:0]  req_nbl, req_nbr, req_agg;
  logic [SID_W-1:0]  nbl_ptr_q, nbr_ptr_q, agg_ptr_q;
  logic [SID_W-1:0]  nbl_g, nbr_g, agg_g;
  logic              nbl_hit, nbr_hit, agg_hit;
  logic              nbl_fire, nbr_fire, agg_fire, xf_fire;
  logic [CNT_W-1:0]  agg_cnt;

  function automatic logic [SID_W:0] rr_pick(input logic [SLOTS-1:0] req,
                                             input logic [SID_W-1:0] ptr);
    logic             hit;
    logic [SID_W-1:0] idx;
    int               j;
    hit = 1'b0;
    idx = ptr;
    for (int k = 0; k < SLOTS; k++) begin
      j = (int'(ptr) + k) % SLOTS;
      if (!hit && req[j]) begin
        hit = 1'b1;
        idx = SID_W'(j);
      end
    end
    return {hit, idx};
  endfunction

  function automatic logic [SID_W-1:0] after(input logic [SID_W-1:0] g);
    return (int'(g) == SLOTS - 1) ? '0 : g + 1'b1;
  endfunction

  always_comb begin
    agg_cnt = '0;
    for (int i = 0; i < SLOTS; i++) begin
      req_nbl[i]    = (st_q[i] == S_PROG);
      req_nbr[i]    = (st_q[i] == S_NBR) && pend_q[i];
      req_agg[i]    = (st_q[i] == S_AGG) && pend_q[i];
      empty_mask[i] = (st_q[i] == S_EMPTY);
      agg_cnt       = agg_cnt + CNT_W'(agd_q[i]);
    end
  end

  assign {nbl_hit, nbl_g} = rr_pick(req_nbl, nbl_ptr_q);
  assign {nbr_hit, nbr_g} = rr_pick(req_nbr, nbr_ptr_q);
  assign {agg_hit, agg_g} = rr_pick(req_agg, agg_ptr_q);

  assign nbl_req_valid = nbl_hit;
  assign nbl_req_slot  = nbl_g;
  assign nbl_req_addr  = addr_q[nbl_g];
  assign nbr_req_valid = nbr_hit;
  assign nbr_req_slot  = nbr_g;
  assign agg_req_valid = agg_hit;
  assign agg_req_slot  = agg_g;
  assign agg_req_node  = node_q[agg_g];
  assign agg_req_prec  = prec_q[agg_g];
  assign xf_req_valid  = (xform_wait != '0) && (agg_cnt >= xform_wait);
  assign xf_req_mask   = agd_q;

  assign nbl_fire = nbl_req_valid && nbl_req_ready;
  assign nbr_fire = nbr_req_valid && nbr_req_ready;
  assign agg_fire = agg_req_valid && agg_req_ready;
  assign xf_fire  = xf_req_valid && xf_req_ready;

  assign fetched_mask = fetched_q;
  assign irq_mask     = irq_q;
  assign irq          = |irq_q;

  always_ff @(posedge clk) begin
    for (int i = 0; i < SLOTS; i++)
      if (prog_we && prog_slot == SID_W'(i) && st_q[i] == S_EMPTY) begin
        node_q[i] <= prog_node;
        prec_q[i] <= prog_prec;
        addr_q[i] <= prog_addr;
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      nbl_ptr_q <= '0;
      nbr_ptr_q <= '0;
      agg_ptr_q <= '0;
    end else begin
      if (nbl_fire) nbl_ptr_q <= after(nbl_g);
      if (nbr_fire) nbr_ptr_q <= after(nbr_g);
      if (agg_fire) agg_ptr_q <= after(agg_g);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SLOTS; i++) st_q[i] <= S_EMPTY;
      pend_q    <= '0;
      agd_q     <= '0;
      fetched_q <= '0;
      irq_q     <= '0;
    end else begin
      for (int i = 0; i < SLOTS; i++) begin
        irq_q[i] <= (irq_q[i] & ~irq_clear[i]) |
                    (st_q[i] == S_XF && xf_done_valid && xf_done_slot == SID_W'(i));
        if (late_done_valid && late_done_slot == SID_W'(i) && st_q[i] != S_EMPTY)
          fetched_q[i] <= 1'b1;
        case (st_q[i])
          S_EMPTY:
            if (make_valid[i]) begin
              st_q[i]      <= S_PROG;
              fetched_q[i] <= 1'b0;
              pend_q[i]    <= 1'b0;
              agd_q[i]     <= 1'b0;
            end
          S_PROG:
            if (nbl_fire && nbl_g == SID_W'(i)) st_q[i] <= S_NBL;
          S_NBL:
            if (nbl_done_valid && nbl_done_slot == SID_W'(i)) begin
              st_q[i]   <= S_NBR;
              pend_q[i] <= 1'b1;
            end
          S_NBR:
            if (pend_q[i]) begin
              if (nbr_fire && nbr_g == SID_W'(i)) pend_q[i] <= 1'b0;
            end else if (nbr_done_valid && nbr_done_slot == SID_W'(i)) begin
              st_q[i]   <= S_AGG;
              pend_q[i] <= 1'b1;
              if (!nbr_done_partial) fetched_q[i] <= 1'b1;
            end
          S_AGG:
            if (pend_q[i]) begin
              if (agg_fire && agg_g == SID_W'(i)) pend_q[i] <= 1'b0;
            end else if (agd_q[i]) begin
              if (xf_fire) begin
                st_q[i]  <= S_XF;
                agd_q[i] <= 1'b0;
              end
            end else if (agg_done_valid && agg_done_slot == SID_W'(i)) begin
              agd_q[i] <= 1'b1;
            end
          S_XF:
            if (xf_done_valid && xf_done_slot == SID_W'(i)) st_q[i] <= S_EMPTY;
          default: st_q[i] <= S_EMPTY;
        endcase
      end
    end
  end

endmodule

// File: rtl/node_slot_scoreboard_chk.sv
module node_slot_scoreboard_chk #(
  parameter int SLOTS = 64,
  localparam int SID_W = $clog2(SLOTS),
  localparam int CNT_W = $clog2(SLOTS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic [SLOTS-1:0] make_valid,
  input logic [SLOTS-1:0] empty_mask,
  input logic [SLOTS-1:0] irq_mask,
  input logic [SLOTS-1:0] irq_clear,
  input logic [SLOTS-1:0] xf_req_mask,
  input logic             nbl_req_valid,
  input logic             nbl_req_ready,
  input logic [SID_W-1:0] nbl_req_slot,
  input logic             xf_req_valid,
  input logic [CNT_W-1:0] xform_wait,
  input logic             irq
);

  p_mv_leaves_empty_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (make_valid & empty_mask) != '0 |=> ($past(make_valid & empty_mask) & empty_mask) == '0);

  p_req_slot_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nbl_req_valid |-> !empty_mask[nbl_req_slot]);

  p_backpressure_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    nbl_req_valid && !nbl_req_ready |=> nbl_req_valid);

  p_xf_threshold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xf_req_valid |-> (xform_wait != '0) && ($countones(xf_req_mask) >= int'(xform_wait)));

  p_xf_mask_busy_r7: assert property (@(posedge clk) disable iff (!rst_n)
    xf_req_valid |-> (xf_req_mask & empty_mask) == '0);

  p_irq_level_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_mask & ~irq_clear) != '0 |=> irq);

endmodule

bind node_slot_scoreboard node_slot_scoreboard_chk #(.SLOTS(SLOTS)) chk_i (
  .clk(clk), .rst_n(rst_n), .make_valid(make_valid), .empty_mask(empty_mask),
  .irq_mask(irq_mask), .irq_clear(irq_clear), .xf_req_mask(xf_req_mask),
  .nbl_req_valid(nbl_req_valid), .nbl_req_ready(nbl_req_ready),
  .nbl_req_slot(nbl_req_slot), .xf_req_valid(xf_req_valid),
  .xform_wait(xform_wait), .irq(irq)
);

// File: tb/node_slot_scoreboard_tb_top.sv
module node_slot_scoreboard_tb_top;
  localparam int SLOTS = 4, SID_W = 2, CNT_W = 3;
  localparam int NODE_W = 20, PREC_W = 2, ADDR_W = 32;

  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic rst_n, prog_we;
  logic [SID_W-1:0] prog_slot;
  logic [NODE_W-1:0] prog_node;
  logic [PREC_W-1:0] prog_prec;
  logic [ADDR_W-1:0] prog_addr;
  logic [SLOTS-1:0] make_valid, irq_clear;
  logic [CNT_W-1:0] xform_wait;
  logic nbl_req_valid, nbl_req_ready, nbl_done_valid;
  logic [SID_W-1:0] nbl_req_slot, nbl_done_slot;
  logic [ADDR_W-1:0] nbl_req_addr;
  logic nbr_req_valid, nbr_req_ready, nbr_done_valid, nbr_done_partial;
  logic [SID_W-1:0] nbr_req_slot, nbr_done_slot;
  logic late_done_valid;
  logic [SID_W-1:0] late_done_slot;
  logic agg_req_valid, agg_req_ready, agg_done_valid;
  logic [SID_W-1:0] agg_req_slot, agg_done_slot;
  logic [NODE_W-1:0] agg_req_node;
  logic [PREC_W-1:0] agg_req_prec;
  logic xf_req_valid, xf_req_ready, xf_done_valid;
  logic [SLOTS-1:0] xf_req_mask;
  logic [SID_W-1:0] xf_done_slot;
  logic [SLOTS-1:0] empty_mask, fetched_mask, irq_mask;
  logic irq;

  node_slot_scoreboard #(.SLOTS(SLOTS), .NODE_W(NODE_W), .PREC_W(PREC_W), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .prog_we(prog_we), .prog_slot(prog_slot),
    .prog_node(prog_node), .prog_prec(prog_prec), .prog_addr(prog_addr),
    .make_valid(make_valid), .irq_clear(irq_clear), .xform_wait(xform_wait),
    .nbl_req_valid(nbl_req_valid), .nbl_req_ready(nbl_req_ready),
    .nbl_req_slot(nbl_req_slot), .nbl_req_addr(nbl_req_addr),
    .nbl_done_valid(nbl_done_valid), .nbl_done_slot(nbl_done_slot),
    .nbr_req_valid(nbr_req_valid), .nbr_req_ready(nbr_req_ready),
    .nbr_req_slot(nbr_req_slot), .nbr_done_valid(nbr_done_valid),
    .nbr_done_slot(nbr_done_slot), .nbr_done_partial(nbr_done_partial),
    .late_done_valid(late_done_valid), .late_done_slot(late_done_slot),
    .agg_req_valid(agg_req_valid), .agg_req_ready(agg_req_ready),
    .agg_req_slot(agg_req_slot), .agg_req_node(agg_req_node),
    .agg_req_prec(agg_req_prec), .agg_done_valid(agg_done_valid),
    .agg_done_slot(agg_done_slot), .xf_req_valid(xf_req_valid),
    .xf_req_ready(xf_req_ready), .xf_req_mask(xf_req_mask),
    .xf_done_valid(xf_done_valid), .xf_done_slot(xf_done_slot),
    .empty_mask(empty_mask), .fetched_mask(fetched_mask),
    .irq_mask(irq_mask), .irq(irq)
  );

  int n_chk = 0, n_bad = 0;
  bit finished = 1'b0;

  task automatic eq(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n = 1);
    repeat (n) @(negedge clk);
  endtask

  task automatic prog(input int s, input int node, input int prec, input logic [31:0] addr);
    prog_we = 1'b1; prog_slot = SID_W'(s); prog_node = NODE_W'(node);
    prog_prec = PREC_W'(prec); prog_addr = addr;
    cyc(); prog_we = 1'b0;
  endtask

  task automatic mv(input logic [SLOTS-1:0] m);
    make_valid = m; cyc(); make_valid = '0;
  endtask

  task automatic nbl_done(input int s);
    nbl_done_valid = 1'b1; nbl_done_slot = SID_W'(s); cyc(); nbl_done_valid = 1'b0;
  endtask

  task automatic nbr_done(input int s, input bit partial);
    nbr_done_valid = 1'b1; nbr_done_slot = SID_W'(s); nbr_done_partial = partial;
    cyc(); nbr_done_valid = 1'b0; nbr_done_partial = 1'b0;
  endtask

  task automatic agg_done(input int s);
    agg_done_valid = 1'b1; agg_done_slot = SID_W'(s); cyc(); agg_done_valid = 1'b0;
  endtask

  task automatic xf_done(input int s, input logic [SLOTS-1:0] clr);
    xf_done_valid = 1'b1; xf_done_slot = SID_W'(s); irq_clear = clr;
    cyc(); xf_done_valid = 1'b0; irq_clear = '0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; prog_we = 1'b0; prog_slot = '0; prog_node = '0; prog_prec = '0;
    prog_addr = '0; make_valid = '0; irq_clear = '0; xform_wait = 3'd3;
    nbl_req_ready = 1'b0; nbl_done_valid = 1'b0; nbl_done_slot = '0;
    nbr_req_ready = 1'b0; nbr_done_valid = 1'b0; nbr_done_slot = '0; nbr_done_partial = 1'b0;
    late_done_valid = 1'b0; late_done_slot = '0; agg_req_ready = 1'b0;
    agg_done_valid = 1'b0; agg_done_slot = '0; xf_req_ready = 1'b0;
    xf_done_valid = 1'b0; xf_done_slot = '0;
    cyc(3); rst_n = 1'b1; cyc();

    eq("R1 empty_mask", empty_mask, 4'hF);
    eq("R1 irq_mask", irq_mask, 0);
    eq("R1 irq", irq, 0);
    eq("R1 fetched_mask", fetched_mask, 0);
    eq("R1 nbl_req_valid", nbl_req_valid, 0);
    eq("R1 xf_req_valid", xf_req_valid, 0);

    for (int s = 0; s < SLOTS; s++) prog(s, 100 + s, s, 32'h1000 + 32'(16 * s));

    mv(4'b0101);
    eq("R2 empty after strobe", empty_mask, 4'b1010);
    eq("R4 nbl valid", nbl_req_valid, 1);
    eq("R6 nbl first grant", nbl_req_slot, 0);
    eq("R3 nbl addr slot0", nbl_req_addr, 32'h1000);
    prog(0, 999, 3, 32'hDEAD);
    eq("R4 held under backpressure", nbl_req_valid, 1);
    eq("R3 busy write ignored", nbl_req_addr, 32'h1000);

    nbl_req_ready = 1'b1;
    eq("R6 grant slot0", nbl_req_slot, 0);
    cyc();
    eq("R6 grant slot2 valid", nbl_req_valid, 1);
    eq("R6 grant slot2", nbl_req_slot, 2);
    eq("R3 nbl addr slot2", nbl_req_addr, 32'h1020);
    cyc();
    eq("R4 no request left", nbl_req_valid, 0);
    cyc(2);
    mv(4'b1011);
    eq("R2 busy strobes ignored", empty_mask, 4'b0000);
    eq("R6 wrapped pointer grant slot3", nbl_req_slot, 3);
    cyc();
    eq("R6 wrap grant slot1", nbl_req_slot, 1);
    cyc();
    eq("R2 no re-entry of busy slots", nbl_req_valid, 0);
    nbl_req_ready = 1'b0;

    nbl_done(2);
    eq("R5 nbr request after list done", nbr_req_valid, 1);
    eq("R5 nbr slot2", nbr_req_slot, 2);
    nbr_req_ready = 1'b1; cyc(); nbr_req_ready = 1'b0;
    eq("R5 nbr accepted", nbr_req_valid, 0);
    nbl_done(2);
    eq("R11 stray list done ignored", nbr_req_valid, 0);
    nbl_done(0); nbl_done(1); nbl_done(3);
    eq("R6 nbr pointer after slot2", nbr_req_slot, 3);
    nbr_req_ready = 1'b1;
    cyc();
    eq("R6 nbr wrap slot0", nbr_req_slot, 0);
    cyc();
    eq("R6 nbr slot1", nbr_req_slot, 1);
    cyc();
    eq("R6 nbr drained", nbr_req_valid, 0);
    nbr_req_ready = 1'b0;

    nbr_done(0, 0); nbr_done(1, 1); nbr_done(2, 0); nbr_done(3, 1);
    eq("R10 ok dones set fetched", fetched_mask, 4'b0101);
    eq("R5 agg valid", agg_req_valid, 1);
    eq("R5 agg slot0", agg_req_slot, 0);
    eq("R3 agg node slot0", agg_req_node, 100);
    late_done_valid = 1'b1; late_done_slot = 2'd1; cyc(); late_done_valid = 1'b0;
    eq("R10 late update", fetched_mask, 4'b0111);
    agg_req_ready = 1'b1;
    cyc();
    eq("R6 agg slot1", agg_req_slot, 1);
    eq("R3 agg prec slot1", agg_req_prec, 1);
    cyc(2);
    eq("R6 agg slot3", agg_req_slot, 3);
    eq("R3 agg node slot3", agg_req_node, 103);
    cyc();
    eq("R5 agg drained", agg_req_valid, 0);
    agg_req_ready = 1'b0;

    agg_done(2);
    eq("R7 count 1 below wait", xf_req_valid, 0);
    agg_done(0);
    eq("R7 count 2 below wait", xf_req_valid, 0);
    agg_done(3);
    eq("R7 count reaches wait", xf_req_valid, 1);
    eq("R7 batch mask", xf_req_mask, 4'b1101);
    agg_done(1);
    eq("R7 batch grows while held", xf_req_mask, 4'b1111);
    xf_req_ready = 1'b1; cyc(); xf_req_ready = 1'b0;
    eq("R7 batch accepted", xf_req_valid, 0);
    eq("R7 slots still busy", empty_mask, 0);

    xf_done(1, '0);
    eq("R8 slot1 free", empty_mask, 4'b0010);
    eq("R8 irq bit", irq_mask, 4'b0010);
    eq("R9 irq level", irq, 1);
    irq_clear = 4'b0010; cyc(); irq_clear = '0;
    eq("R9 w1c clears", irq_mask, 0);
    eq("R9 irq low", irq, 0);
    xf_done(3, 4'b1000);
    eq("R9 set wins over clear", irq_mask, 4'b1000);
    irq_clear = 4'b1000; cyc(); irq_clear = '0;
    eq("R9 cleared", irq_mask, 0);

    nbr_done(1, 0);
    eq("R11 stray done on free slot", empty_mask, 4'b1010);
    eq("R11 no agg request", agg_req_valid, 0);

    prog(1, 555, 2, 32'h2222);
    mv(4'b0010);
    eq("R8 slot reused", empty_mask, 4'b1000);
    eq("R8 new request", nbl_req_slot, 1);
    eq("R3 new address", nbl_req_addr, 32'h2222);
    eq("R10 cleared on revalid", fetched_mask, 4'b0101);

    finished = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule